// File: doc/BRIEF.md
# Half-Duplex Smart-Card Serial Port with Parity Refusal

This block is an asynchronous serial port for a card interface in which the transmit and receive pins share one open-drain line. The transmitter and the receiver both watch the shared line. Each character is sent as one frame: a start bit, eight data bits, a parity bit and a stop bit. When the receiver detects a parity error, it refuses the character by pulling the line low during the stop-bit slot. When the other side refuses a character this port sent, the transmitter sees the line low in the stop-bit slot and records a refusal flag.

The bit rate comes from a reload counter that counts ticks of a prescaled clock. Each bit period holds sixteen overflows of that counter. Software writes a byte to a holding buffer, and the byte moves into the shift register at the next counter overflow. A status flag reports when the holding buffer is empty, and another reports when the shift register is idle. A selectable event raises the transmit interrupt. A receive-complete flag, a parity-error flag and a receive interrupt report incoming characters.

The transmit machine has the states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP:
- TX_IDLE goes to TX_START on a load: the buffer is full, the transmitter is enabled and an overflow occurs.
- The machine goes from TX_START to TX_DATA, and from TX_PARITY to TX_STOP, at the end of a bit.
- It goes from TX_DATA to TX_PARITY at the end of the eighth data bit.
- It goes from TX_STOP back to TX_IDLE at the end of the stop bit.

The receive machine has the states RX_IDLE, RX_START, RX_DATA, RX_PARITY and RX_STOP:
- RX_IDLE goes to RX_START when the receiver is enabled and it sees a low line on an overflow.
- RX_START goes back to RX_IDLE if the line is high at the middle of the start bit. It goes to RX_DATA at the end of the start bit.
- RX_DATA goes to RX_PARITY after eight bits.
- RX_PARITY goes to RX_STOP at the end of the parity bit.
- RX_STOP goes to RX_IDLE at the end of the stop slot, and the character completes at that moment.

Top module: `sc_uart`

## Requirements
- R1: One bit lasts 16*(baud_reload+1)*D clock cycles. D is 1 for div_sel=0, 8 for div_sel=1 and 32 for div_sel=2 or 3.
- R2: The line idles high (1). A frame is a 0 start bit, then data bits 0 to 7 with the least significant bit first, then the parity bit, then a 1 stop bit.
- R3: With odd_par=0, the parity bit makes the count of ones over data and parity even. With odd_par=1, it makes that count odd. The same rule is used when sending and when checking.
- R4: A wr_tx pulse makes tbuf_empty 0 from the next cycle. At the first overflow at which the shift register is idle and tx_en=1, the byte moves to the shift register and tbuf_empty returns to 1. While tx_en=0, nothing is sent and tbuf_empty stays 0.
- R5: tx_shift_empty is 0 from the load until the stop bit has finished, and 1 otherwise.
- R6: With tx_irq_on_empty=1, irq_tx sets on a load. With tx_irq_on_empty=0, it sets when a frame finishes. It then holds at 1 until a tx_irq_clr pulse clears it on the next cycle.
- R7: At the end of the stop slot, rx_done and irq_rx set and rx_data holds the received byte. An rd_rx pulse clears rx_done and rx_perr. A rx_irq_clr pulse clears irq_rx.
- R8: A low level that has gone high again by the middle of the start bit does not start a frame.
- R9: On a parity mismatch, the receiver holds line_o low for the whole stop slot and sets rx_perr. On correct parity it leaves the line released.
- R10: tx_nak_seen takes the inverted line level at the middle of the stop bit of each sent frame. The next load clears it.
- R11: While rx_en=0, the receiver ignores the line: it sets no flag, leaves rx_data unchanged and drives no refusal.
- R12: After reset, line_o=1, tbuf_empty=1 and tx_shift_empty=1, and tx_nak_seen, rx_done, rx_perr, irq_tx and irq_rx are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 2 | Prescaler select: 0 gives /1, 1 gives /8, 2 or 3 gives /32 |
| baud_reload | input | 8 | Reload value n of the baud counter |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| tx_irq_on_empty | input | 1 | Transmit interrupt source: 1 for buffer empty, 0 for frame done |
| wr_tx | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| rd_rx | input | 1 | Read strobe for the receive buffer |
| tx_irq_clr | input | 1 | Acknowledge or clear of the transmit interrupt |
| rx_irq_clr | input | 1 | Acknowledge or clear of the receive interrupt |
| line_i | input | 1 | Level of the shared line |
| line_o | output | 1 | Open-drain drive: 0 pulls the line low, 1 releases it |
| rx_data | output | 8 | Last received byte |
| tbuf_empty | output | 1 | Holding buffer empty |
| tx_shift_empty | output | 1 | Shift register idle |
| tx_nak_seen | output | 1 | A refusal was seen in the last stop bit sent |
| rx_done | output | 1 | A received character is waiting |
| rx_perr | output | 1 | The received character had a parity error |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
Random bytes are sent at random reload values, with random parity sense and random interrupt source. This separates bit order, parity polarity and the two interrupt sources from one another. Three prescaler settings are measured on the length of the start bit, which isolates the count-source selection from the reload.

Received frames carry correct or deliberately wrong parity. This tells a refused character from an accepted one, both on the line during the stop slot and in the status flags. Directed cases cover four situations:
- a short glitch, which must be rejected;
- a disabled receiver and a disabled transmitter;
- a write that arrives while a frame is shifting, so the buffer and shift-register flags diverge;
- a refusal injected into a transmitted stop bit, followed by a clean frame that must clear the refusal flag.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
    localparam int SUBTICKS = 16;
    localparam int SUB_W    = $clog2(SUBTICKS);

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/sc_uart_brg.sv
module sc_uart_brg #(
    parameter int RELOAD_W    = 8,
    parameter int SLOW_DIV    = 8,
    parameter int SLOWEST_DIV = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          div_sel,
    input  logic [RELOAD_W-1:0] reload,
    output logic                subtick
);
    localparam int PRE_W = $clog2(SLOWEST_DIV);

    logic [PRE_W-1:0]    pre_q;
    logic [PRE_W-1:0]    pre_limit;
    logic [RELOAD_W-1:0] cnt_q;
    logic                src_tick;

    always_comb begin
        unique case (div_sel)
            2'd0:    pre_limit = '0;
            2'd1:    pre_limit = PRE_W'(SLOW_DIV - 1);
            default: pre_limit = PRE_W'(SLOWEST_DIV - 1);
        endcase
    end

    assign src_tick = (pre_q >= pre_limit);
    assign subtick  = src_tick && (cnt_q >= reload);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= src_tick ? '0 : pre_q + 1'b1;
            if (src_tick) begin
                cnt_q <= (cnt_q >= reload) ? '0 : cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx
    import sc_uart_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              subtick,
    input  logic              tx_en,
    input  logic              odd_par,
    input  logic              irq_on_empty,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_clr,
    input  logic              line_i,
    output logic              tx_line,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              nak_seen,
    output logic              irq
);
    localparam int BIT_W = $clog2(DATA_W);

    tx_state_e         state_q, state_d;
    logic [SUB_W-1:0]  sub_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] hold_q;
    logic              hold_full_q;
    logic              par_q;
    logic              bit_end, mid_bit, load, frame_done;

    assign bit_end    = subtick && (sub_q == SUB_W'(SUBTICKS - 1));
    assign mid_bit    = subtick && (sub_q == SUB_W'(SUBTICKS / 2 - 1));
    assign load       = (state_q == TX_IDLE) && hold_full_q && tx_en && subtick;
    assign frame_done = (state_q == TX_STOP) && bit_end;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (load) state_d = TX_START;
            TX_START:  if (bit_end) state_d = TX_DATA;
            TX_DATA:   if (bit_end && bit_q == BIT_W'(DATA_W - 1)) state_d = TX_PARITY;
            TX_PARITY: if (bit_end) state_d = TX_STOP;
            TX_STOP:   if (bit_end) state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    // state register with its slot counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            sub_q   <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE) begin
                sub_q <= '0;
                bit_q <= '0;
            end else if (subtick) begin
                sub_q <= sub_q + 1'b1;
                if (state_q == TX_DATA && bit_end) bit_q <= bit_q + 1'b1;
            end
        end
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            shift_q     <= '0;
            par_q       <= 1'b0;
            nak_seen    <= 1'b0;
            irq         <= 1'b0;
        end else begin
            if (wr) begin
                hold_q      <= wdata;
                hold_full_q <= 1'b1;
            end else if (load) begin
                hold_full_q <= 1'b0;
            end
            if (load) begin
                shift_q  <= hold_q;
                par_q    <= (^hold_q) ^ odd_par;
                nak_seen <= 1'b0;
            end else if (state_q == TX_DATA && bit_end) begin
                shift_q <= shift_q >> 1;
            end
            if (state_q == TX_STOP && mid_bit) nak_seen <= !line_i;
            if (irq_on_empty ? load : frame_done) irq <= 1'b1;
            else if (irq_clr)                     irq <= 1'b0;
        end
    end

    // line level per state
    always_comb begin
        unique case (state_q)
            TX_START:  tx_line = 1'b0;
            TX_DATA:   tx_line = shift_q[0];
            TX_PARITY: tx_line = par_q;
            default:   tx_line = 1'b1;
        endcase
    end

    assign buf_empty   = !hold_full_q;
    assign shift_empty = (state_q == TX_IDLE);
endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx
    import sc_uart_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              subtick,
    input  logic              rx_en,
    input  logic              odd_par,
    input  logic              line_i,
    input  logic              rd,
    input  logic              irq_clr,
    output logic              nak_drive,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              perr,
    output logic              irq
);
    localparam int BIT_W = $clog2(DATA_W);

    rx_state_e         state_q, state_d;
    logic [SUB_W-1:0]  sub_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              sync1_q, line_s;
    logic              perr_pend_q;
    logic              bit_end, mid_bit, complete;

    assign bit_end  = subtick && (sub_q == SUB_W'(SUBTICKS - 1));
    assign mid_bit  = subtick && (sub_q == SUB_W'(SUBTICKS / 2 - 1));
    assign complete = (state_q == RX_STOP) && bit_end;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (rx_en && subtick && !line_s) state_d = RX_START;
            RX_START: begin
                if (mid_bit && line_s) state_d = RX_IDLE;
                else if (bit_end)      state_d = RX_DATA;
            end
            RX_DATA:   if (bit_end && bit_q == BIT_W'(DATA_W - 1)) state_d = RX_PARITY;
            RX_PARITY: if (bit_end) state_d = RX_STOP;
            RX_STOP:   if (bit_end) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    // state register with its slot counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            sub_q   <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RX_IDLE) begin
                sub_q <= '0;
                bit_q <= '0;
            end else if (subtick) begin
                sub_q <= sub_q + 1'b1;
                if (state_q == RX_DATA && bit_end) bit_q <= bit_q + 1'b1;
            end
        end
    end

    // line synchroniser, sampling and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q     <= 1'b1;
            line_s      <= 1'b1;
            shift_q     <= '0;
            perr_pend_q <= 1'b0;
            rdata       <= '0;
            done        <= 1'b0;
            perr        <= 1'b0;
            irq         <= 1'b0;
        end else begin
            sync1_q <= line_i;
            line_s  <= sync1_q;
            if (state_q == RX_DATA && mid_bit) shift_q <= {line_s, shift_q[DATA_W-1:1]};
            if (state_q == RX_PARITY && mid_bit) perr_pend_q <= (^shift_q) ^ line_s ^ odd_par;
            if (complete) begin
                rdata <= shift_q;
                done  <= 1'b1;
                perr  <= perr_pend_q;
            end else if (rd) begin
                done <= 1'b0;
                perr <= 1'b0;
            end
            if (complete)     irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end

    assign nak_drive = (state_q == RX_STOP) && perr_pend_q;
endmodule

// File: rtl/sc_uart.sv
module sc_uart #(
    parameter int DATA_W      = 8,
    parameter int RELOAD_W    = 8,
    parameter int SLOW_DIV    = 8,
    parameter int SLOWEST_DIV = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          div_sel,
    input  logic [RELOAD_W-1:0] baud_reload,
    input  logic                tx_en,
    input  logic                rx_en,
    input  logic                odd_par,
    input  logic                tx_irq_on_empty,
    input  logic                wr_tx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_rx,
    input  logic                tx_irq_clr,
    input  logic                rx_irq_clr,
    input  logic                line_i,
    output logic                line_o,
    output logic [DATA_W-1:0]   rx_data,
    output logic                tbuf_empty,
    output logic                tx_shift_empty,
    output logic                tx_nak_seen,
    output logic                rx_done,
    output logic                rx_perr,
    output logic                irq_tx,
    output logic                irq_rx
);
    logic subtick;
    logic tx_line;
    logic rx_nak;

    sc_uart_brg #(
        .RELOAD_W   (RELOAD_W),
        .SLOW_DIV   (SLOW_DIV),
        .SLOWEST_DIV(SLOWEST_DIV)
    ) u_brg (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_sel(div_sel),
        .reload (baud_reload),
        .subtick(subtick)
    );

    sc_uart_tx #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .subtick     (subtick),
        .tx_en       (tx_en),
        .odd_par     (odd_par),
        .irq_on_empty(tx_irq_on_empty),
        .wr          (wr_tx),
        .wdata       (wr_data),
        .irq_clr     (tx_irq_clr),
        .line_i      (line_i),
        .tx_line     (tx_line),
        .buf_empty   (tbuf_empty),
        .shift_empty (tx_shift_empty),
        .nak_seen    (tx_nak_seen),
        .irq         (irq_tx)
    );

    sc_uart_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .subtick  (subtick),
        .rx_en    (rx_en),
        .odd_par  (odd_par),
        .line_i   (line_i),
        .rd       (rd_rx),
        .irq_clr  (rx_irq_clr),
        .nak_drive(rx_nak),
        .rdata    (rx_data),
        .done     (rx_done),
        .perr     (rx_perr),
        .irq      (irq_rx)
    );

    // open-drain: either side may pull the shared line low
    assign line_o = tx_line && !rx_nak;
endmodule

// File: rtl/sc_uart_chk.sv
module sc_uart_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_tx,
    input logic tbuf_empty,
    input logic tx_shift_empty,
    input logic irq_tx,
    input logic tx_irq_clr,
    input logic irq_rx,
    input logic rx_irq_clr,
    input logic rx_done,
    input logic rx_perr,
    input logic nak_drive
);
    p_buf_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> !tbuf_empty);

    p_load_from_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_shift_empty) |-> ($past(tbuf_empty) == 1'b0));

    p_txirq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx && !tx_irq_clr) |=> irq_tx);

    p_rxirq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && !rx_irq_clr) |=> irq_rx);

    p_done_raises_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> irq_rx);

    p_nak_end_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nak_drive) |-> (rx_done && rx_perr));
endmodule

bind sc_uart sc_uart_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_tx         (wr_tx),
    .tbuf_empty    (tbuf_empty),
    .tx_shift_empty(tx_shift_empty),
    .irq_tx        (irq_tx),
    .tx_irq_clr    (tx_irq_clr),
    .irq_rx        (irq_rx),
    .rx_irq_clr    (rx_irq_clr),
    .rx_done       (rx_done),
    .rx_perr       (rx_perr),
    .nak_drive     (rx_nak)
);

// File: tb/sc_uart_tb.sv
`timescale 1ns/1ps
module sc_uart_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] div_sel;
    logic [7:0] baud_reload;
    logic       tx_en, rx_en, odd_par, tx_irq_on_empty;
    logic       wr_tx, rd_rx, tx_irq_clr, rx_irq_clr;
    logic [7:0] wr_data;
    logic       card_o;
    logic       line_o;
    logic [7:0] rx_data;
    logic       tbuf_empty, tx_shift_empty, tx_nak_seen;
    logic       rx_done, rx_perr, irq_tx, irq_rx;
    logic       bus_line;

    int n_checks = 0;
    int n_err    = 0;

    always #2.5 clk = ~clk;
    assign bus_line = line_o & card_o;

    sc_uart u_dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .baud_reload(baud_reload),
        .tx_en(tx_en), .rx_en(rx_en), .odd_par(odd_par), .tx_irq_on_empty(tx_irq_on_empty),
        .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx), .tx_irq_clr(tx_irq_clr),
        .rx_irq_clr(rx_irq_clr), .line_i(bus_line), .line_o(line_o), .rx_data(rx_data),
        .tbuf_empty(tbuf_empty), .tx_shift_empty(tx_shift_empty), .tx_nak_seen(tx_nak_seen),
        .rx_done(rx_done), .rx_perr(rx_perr), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    function automatic int bit_period(input logic [1:0] sel, input int n);
        int d;
        d = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 8 : 32;
        return 16 * (n + 1) * d;
    endfunction

    function automatic logic exp_parity(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nclk(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic write_tx(input logic [7:0] d);
        wr_data = d;
        wr_tx   = 1'b1;
        @(negedge clk);
        wr_tx   = 1'b0;
    endtask

    task automatic pulse_tx_clr();
        tx_irq_clr = 1'b1; @(negedge clk); tx_irq_clr = 1'b0;
    endtask

    task automatic pulse_rx_clr();
        rx_irq_clr = 1'b1; @(negedge clk); rx_irq_clr = 1'b0;
    endtask

    task automatic pulse_rd();
        rd_rx = 1'b1; @(negedge clk); rd_rx = 1'b0;
    endtask

    task automatic wait_tx_idle(input int limit);
        int t = 0;
        while (tx_shift_empty !== 1'b1 && t < limit) begin @(negedge clk); t++; end
    endtask

    // sample a frame from the line at mid-bit; optionally refuse it in the stop slot
    task automatic decode_tx(input int bp, input bit nak, output logic [7:0] d,
                             output logic p, output logic s, output bit found);
        int t = 0;
        while (bus_line !== 1'b0 && t < bp * 40) begin @(negedge clk); t++; end
        found = (bus_line === 1'b0);
        nclk(bp / 2);
        for (int i = 0; i < 8; i++) begin nclk(bp); d[i] = bus_line; end
        nclk(bp);
        p = bus_line;
        if (nak) begin
            nclk(bp / 2); card_o = 1'b0;
            nclk(bp / 2); s = bus_line;
            nclk(bp / 2); card_o = 1'b1;
        end else begin
            nclk(bp);
            s = bus_line;
        end
    endtask

    task automatic measure_low(output int len);
        int t = 0;
        while (bus_line !== 1'b0 && t < 100000) begin @(negedge clk); t++; end
        len = 0;
        while (bus_line === 1'b0 && len < 100000) begin len++; @(negedge clk); end
    endtask

    // card side sends a frame; returns line level at stop mid and one bit later
    task automatic card_send(input logic [7:0] d, input logic pbit, input int bp,
                             output logic at_mid, output logic later);
        card_o = 1'b0; nclk(bp);
        for (int i = 0; i < 8; i++) begin card_o = d[i]; nclk(bp); end
        card_o = pbit; nclk(bp);
        card_o = 1'b1; nclk(bp / 2);
        at_mid = bus_line;
        nclk(bp);
        later = bus_line;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] gd, d, d2, prev;
        logic       gp, gs, gp2, gs2, at_mid, later, pb, ods, isel;
        bit         found, found2;
        int         len, bp, n;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; div_sel = 2'd0; baud_reload = 8'd0;
        tx_en = 1'b1; rx_en = 1'b0; odd_par = 1'b0; tx_irq_on_empty = 1'b1;
        wr_tx = 1'b0; rd_rx = 1'b0; tx_irq_clr = 1'b0; rx_irq_clr = 1'b0;
        wr_data = 8'h00; card_o = 1'b1;
        nclk(5);
        rst_n = 1'b1;
        nclk(2);

        // R12 reset state
        check_eq("R12 line_o", line_o, 1);
        check_eq("R12 tbuf_empty", tbuf_empty, 1);
        check_eq("R12 tx_shift_empty", tx_shift_empty, 1);
        check_eq("R12 flags", {tx_nak_seen, rx_done, rx_perr, irq_tx, irq_rx}, 0);

        // R4 / R5 / R6 directed, R1 at /1 n=0
        write_tx(8'h01);
        check_eq("R4 tbuf_empty after write", tbuf_empty, 0);
        check_eq("R5 idle before load", tx_shift_empty, 1);
        nclk(1);
        check_eq("R4 tbuf_empty after load", tbuf_empty, 1);
        check_eq("R5 busy after load", tx_shift_empty, 0);
        check_eq("R6 irq on load", irq_tx, 1);
        measure_low(len);
        check_eq("R1 bit period div1 n0", len, bit_period(2'd0, 0));
        wait_tx_idle(4000);
        pulse_tx_clr();
        check_eq("R6 irq cleared", irq_tx, 0);

        // R1 other count sources
        div_sel = 2'd1; baud_reload = 8'd1; nclk(2);
        write_tx(8'h55);
        measure_low(len);
        check_eq("R1 bit period div8 n1", len, bit_period(2'd1, 1));
        wait_tx_idle(20000);
        div_sel = 2'd2; baud_reload = 8'd0; nclk(2);
        write_tx(8'hA3);
        measure_low(len);
        check_eq("R1 bit period div32 n0", len, bit_period(2'd2, 0));
        wait_tx_idle(40000);
        pulse_tx_clr();

        // R2 R3 R5 R6 R10 random transmit frames
        div_sel = 2'd0;
        for (int k = 0; k < 10; k++) begin
            n = $urandom_range(3, 0);
            baud_reload = 8'(n);
            ods = 1'($urandom_range(1, 0));
            isel = 1'($urandom_range(1, 0));
            d = 8'($urandom_range(255, 0));
            if (k == 0) d = 8'h00;
            if (k == 1) d = 8'hFF;
            odd_par = ods; tx_irq_on_empty = isel;
            bp = bit_period(2'd0, n);
            nclk(2);
            write_tx(d);
            fork
                decode_tx(bp, 1'b0, gd, gp, gs, found);
                begin
                    nclk(8);
                    check_eq("R4 loaded", tbuf_empty, 1);
                    check_eq("R5 shifting", tx_shift_empty, 0);
                    check_eq("R6 irq by source", irq_tx, isel);
                end
            join
            check_eq("R2 start bit", found, 1);
            check_eq("R2 data lsb first", gd, d);
            check_eq("R3 parity bit", gp, exp_parity(d, ods));
            check_eq("R2 stop bit", gs, 1);
            wait_tx_idle(bp * 4);
            check_eq("R5 idle after stop", tx_shift_empty, 1);
            check_eq("R6 irq set", irq_tx, 1);
            check_eq("R10 no refusal", tx_nak_seen, 0);
            pulse_tx_clr();
            check_eq("R6 irq clear", irq_tx, 0);
        end

        // R10 refusal seen, then cleared by next load
        baud_reload = 8'd1; odd_par = 1'b0; bp = bit_period(2'd0, 1); nclk(2);
        write_tx(8'h3C);
        decode_tx(bp, 1'b1, gd, gp, gs, found);
        wait_tx_idle(bp * 4);
        check_eq("R10 refusal captured", tx_nak_seen, 1);
        write_tx(8'hC3);
        decode_tx(bp, 1'b0, gd, gp, gs, found);
        check_eq("R10 refusal cleared on load", tx_nak_seen, 0);
        wait_tx_idle(bp * 4);

        // R4 back-to-back: write while shifting
        baud_reload = 8'd0; bp = bit_period(2'd0, 0); nclk(2);
        fork
            begin
                decode_tx(bp, 1'b0, gd, gp, gs, found);
                decode_tx(bp, 1'b0, d2, gp2, gs2, found2);
            end
            begin
                write_tx(8'h96);
                while (tbuf_empty !== 1'b1) @(negedge clk);
                nclk(3);
                write_tx(8'h69);
                check_eq("R4 buffer full while shifting", tbuf_empty, 0);
                check_eq("R5 still shifting", tx_shift_empty, 0);
            end
        join
        check_eq("R4 first byte", gd, 8'h96);
        check_eq("R4 second byte", d2, 8'h69);
        check_eq("R4 second found", found2, 1);
        wait_tx_idle(bp * 4);
        pulse_tx_clr();

        // R4 disabled transmitter
        tx_en = 1'b0;
        write_tx(8'h5A);
        len = 0;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (bus_line === 1'b0) len++;
        end
        check_eq("R4 nothing sent when disabled", len, 0);
        check_eq("R4 buffer kept when disabled", tbuf_empty, 0);
        fork
            decode_tx(bp, 1'b0, gd, gp, gs, found);
            begin nclk(1); tx_en = 1'b1; end
        join
        check_eq("R4 sent after enable", gd, 8'h5A);
        wait_tx_idle(bp * 4);
        pulse_tx_clr();

        // R7 R9 R3 random receive frames
        rx_en = 1'b1;
        for (int k = 0; k < 10; k++) begin
            n = $urandom_range(3, 0);
            baud_reload = 8'(n);
            ods = 1'($urandom_range(1, 0));
            odd_par = ods;
            d = 8'($urandom_range(255, 0));
            pb = exp_parity(d, ods);
            if (k % 3 == 1) pb = ~pb;
            bp = bit_period(2'd0, n);
            nclk(4);
            card_send(d, pb, bp, at_mid, later);
            check_eq("R9 refusal level in stop slot", at_mid, (pb == exp_parity(d, ods)) ? 1 : 0);
            check_eq("R9 line released after slot", later, 1);
            check_eq("R7 rx_done", rx_done, 1);
            check_eq("R7 rx_data", rx_data, d);
            check_eq("R9 rx_perr", rx_perr, (pb == exp_parity(d, ods)) ? 0 : 1);
            check_eq("R7 irq_rx", irq_rx, 1);
            pulse_rd();
            check_eq("R7 rx_done cleared by read", rx_done, 0);
            check_eq("R7 rx_perr cleared by read", rx_perr, 0);
            pulse_rx_clr();
            check_eq("R7 irq_rx cleared", irq_rx, 0);
        end

        // R8 glitch rejection
        baud_reload = 8'd0; odd_par = 1'b0; bp = bit_period(2'd0, 0); nclk(4);
        card_o = 1'b0; nclk(3); card_o = 1'b1;
        nclk(bp * 12);
        check_eq("R8 glitch ignored", rx_done, 0);
        check_eq("R8 no irq on glitch", irq_rx, 0);
        card_send(8'hB1, exp_parity(8'hB1, 1'b0), bp, at_mid, later);
        check_eq("R8 frame after glitch", rx_data, 8'hB1);
        pulse_rd();
        pulse_rx_clr();

        // R11 disabled receiver
        prev = rx_data;
        rx_en = 1'b0; nclk(2);
        card_send(8'h4E, ~exp_parity(8'h4E, 1'b0), bp, at_mid, later);
        check_eq("R11 no refusal when disabled", at_mid, 1);
        check_eq("R11 no rx_done", rx_done, 0);
        check_eq("R11 rx_data unchanged", rx_data, prev);
        check_eq("R11 no irq", irq_rx, 0);

        finish_run();
    end
endmodule